// File: doc/BRIEF.md
# Output tracking fault monitor

This block supervises a bank of driven output channels and tells the controller, through one active-low flag, when any channel has not reached the level it was told to take. For each channel the controller supplies the commanded level and an output-enable bit. The output stage returns two already-digitized feedback bits per channel: one says the sensed output sits in the band near the high rail, the other says it sits in the band near the low rail.

A channel that is enabled and commanded high but not in the high band is in mismatch. A channel that is enabled and commanded low but not in the low band is also in mismatch. The flag drops only after some channel has been in mismatch for a programmable number of consecutive clock cycles. It returns high only after every channel has tracked for a second, longer, programmable number of consecutive cycles.

Because real outputs need time to slew, each commanded change whose settling outlasts the detect delay produces a short low pulse on the flag. That pulse is normal behaviour. A channel that never settles holds the flag low.

Top module: `trk_fault_mon`

## Requirements
- R1: While reset is asserted and after its release, fault_no is 1 and stays 1 as long as no enabled channel is in mismatch.
- R2: An enabled channel with exp_lvl_i=1 is in mismatch when fb_hi_i=0. An enabled channel with exp_lvl_i=0 is in mismatch when fb_lo_i=0. A mid-band reading (both feedback bits 0) is therefore a mismatch for either commanded level.
- R3: A mismatch on any single one of the N_CH channels, with all others tracking, is sufficient to drive fault_no to 0.
- R4: A channel with drv_en_i=0 is excluded from the comparison, so its feedback has no effect on fault_no.
- R5: With fault_no=1, fault_no falls at the DETECT_CYC-th consecutive rising edge that samples a mismatch. A mismatch lasting DETECT_CYC-1 cycles leaves fault_no at 1.
- R6: With fault_no=0, fault_no rises at the CLEAR_CYC-th consecutive rising edge that samples no mismatch. A mismatch that reappears before then restarts this count.
- R7: When a commanded change is followed by feedback that settles L cycles later, with L >= DETECT_CYC, fault_no is low from edge DETECT_CYC to edge L+CLEAR_CYC after the change. When L < DETECT_CYC, fault_no stays high.
- R8: A clean cycle sampled during the detect count restarts that count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exp_lvl_i | input | N_CH | Commanded level per channel |
| drv_en_i | input | N_CH | Output enable per channel; 0 means high impedance, and the channel is not checked |
| fb_hi_i | input | N_CH | Sensed output is within the high-rail band |
| fb_lo_i | input | N_CH | Sensed output is within the low-rail band |
| fault_no | output | 1 | Tracking fault, active low |

## Verification
A wrong comparison term or a wrong enable mask shows up as a flag that stays high when it should fall, or falls when it should not. Either error is visible DETECT_CYC cycles after the offending stimulus. A counter that fails to restart, or that stops at the wrong limit, moves the flag edge by one or more cycles. The bench therefore samples on both sides of every expected edge, so that such an error appears within one cycle of the expected edge. A monitor stuck in either state is seen at the next clear or detect window.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic {
    ST_OK  = 1'b0,
    ST_FLT = 1'b1
  } trk_state_e;

  function automatic int trk_cnt_w(input int det, input int clr);
    int m;
    m = (det > clr) ? det : clr;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/trk_cmp.sv
module trk_cmp #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] exp_lvl_i,
  input  logic [N_CH-1:0] drv_en_i,
  input  logic [N_CH-1:0] fb_hi_i,
  input  logic [N_CH-1:0] fb_lo_i,
  output logic [N_CH-1:0] mism_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic in_band;
    assign in_band   = exp_lvl_i[g] ? fb_hi_i[g] : fb_lo_i[g];
    assign mism_o[g] = drv_en_i[g] & ~in_band;
  end
endmodule

// File: rtl/trk_timer.sv
module trk_timer
  import trk_pkg::*;
#(
  parameter int DETECT_CYC = 4,
  parameter int CLEAR_CYC  = 40,
  parameter int CW         = trk_cnt_w(DETECT_CYC, CLEAR_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mism_i,
  output logic          flt_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] DET_LIM = CW'(DETECT_CYC - 1);
  localparam logic [CW-1:0] CLR_LIM = CW'(CLEAR_CYC - 1);

  trk_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    unique case (st_q)
      ST_OK: if (mism_i) begin
        if (cnt_q == DET_LIM) st_d  = ST_FLT;
        else                  cnt_d = cnt_q + 1'b1;
      end
      ST_FLT: if (!mism_i) begin
        if (cnt_q == CLR_LIM) st_d  = ST_OK;
        else                  cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_OK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign flt_o = (st_q == ST_FLT);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/trk_fault_mon.sv
module trk_fault_mon
  import trk_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int DETECT_CYC = 4,
  parameter int CLEAR_CYC  = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] exp_lvl_i,
  input  logic [N_CH-1:0] drv_en_i,
  input  logic [N_CH-1:0] fb_hi_i,
  input  logic [N_CH-1:0] fb_lo_i,
  output logic            fault_no
);
  localparam int CW = trk_cnt_w(DETECT_CYC, CLEAR_CYC);

  logic [N_CH-1:0] mism;
  logic            any_mism;
  logic            flt;
  logic [CW-1:0]   tmr_cnt;

  trk_cmp #(.N_CH(N_CH)) u_cmp (
    .exp_lvl_i(exp_lvl_i),
    .drv_en_i (drv_en_i),
    .fb_hi_i  (fb_hi_i),
    .fb_lo_i  (fb_lo_i),
    .mism_o   (mism)
  );

  assign any_mism = |mism;

  trk_timer #(
    .DETECT_CYC(DETECT_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .CW        (CW)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mism_i(any_mism),
    .flt_o (flt),
    .cnt_o (tmr_cnt)
  );

  assign fault_no = ~flt;
endmodule

// File: rtl/trk_fault_mon_chk.sv
module trk_fault_mon_chk #(
  parameter int DETECT_CYC = 4,
  parameter int CLEAR_CYC  = 40,
  parameter int CW         = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fault_no,
  input logic          any_mism,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] DET_LIM = CW'(DETECT_CYC - 1);
  localparam logic [CW-1:0] CLR_LIM = CW'(CLEAR_CYC - 1);

  // R1: flag holds high while all channels track
  a_r1_hold_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_no && !any_mism) |=> fault_no);

  // R5: fall only after a full detect run of mismatch
  a_r5_fall_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_no) |-> ($past(any_mism) && $past(cnt) == DET_LIM));

  // R6: rise only after a full clean run
  a_r6_rise_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_no) |-> (!$past(any_mism) && $past(cnt) == CLR_LIM));

  // R6: mismatch in fault state restarts the clear count
  a_r6_clear_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_no && any_mism) |=> (cnt == '0 && !fault_no));

  // R8: clean cycle in ok state restarts the detect count
  a_r8_detect_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_no && !any_mism) |=> cnt == '0);

  // R5: detect count never passes its limit
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_no |-> cnt <= DET_LIM);
endmodule

bind trk_fault_mon trk_fault_mon_chk #(
  .DETECT_CYC(DETECT_CYC),
  .CLEAR_CYC (CLEAR_CYC),
  .CW        (CW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fault_no(fault_no),
  .any_mism(any_mism),
  .cnt     (tmr_cnt)
);

// File: tb/sim_trk_fault_mon.sv
`timescale 1ns/1ps
module sim_trk_fault_mon;
  localparam int N  = 8;
  localparam int D  = 4;
  localparam int C  = 40;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] exp_lvl_i, drv_en_i, fb_hi_i, fb_lo_i;
  logic         fault_no;
  int           n_tests = 0;
  int           n_fail  = 0;
  bit           done    = 1'b0;

  always #5 clk_i = ~clk_i;

  trk_fault_mon #(.N_CH(N), .DETECT_CYC(D), .CLEAR_CYC(C)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .exp_lvl_i(exp_lvl_i), .drv_en_i(drv_en_i),
    .fb_hi_i(fb_hi_i), .fb_lo_i(fb_lo_i), .fault_no(fault_no)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input logic exp_v, input string tag);
    n_tests++;
    if (fault_no !== exp_v) begin
      n_fail++;
      $display("FAIL %s: fault_no=%0b expected %0b", tag, fault_no, exp_v);
    end
  endtask

  task automatic set_match(input logic [N-1:0] lvl);
    exp_lvl_i = lvl;
    drv_en_i  = '1;
    fb_hi_i   = lvl;
    fb_lo_i   = ~lvl;
  endtask

  task automatic recover();
    set_match(8'hA5);
    tick(C + 2);
  endtask

  task automatic t_reset();
    set_match(8'hA5);
    #1 chk(1'b1, "R1 during reset");
    #20 rst_ni = 1'b1;
    tick(50);
    chk(1'b1, "R1 idle after reset");
  endtask

  task automatic t_detect();
    fb_hi_i[0] = 1'b0;
    tick(D - 1);
    chk(1'b1, "R5 short mismatch");
    set_match(8'hA5);
    tick(3);
    chk(1'b1, "R5 after short mismatch");
    fb_hi_i[0] = 1'b0;
    tick(D - 1);
    chk(1'b1, "R5 one before detect");
    tick(1);
    chk(1'b0, "R5 detect edge");
  endtask

  task automatic t_clear();
    set_match(8'hA5);
    tick(C - 1);
    chk(1'b0, "R6 one before clear");
    tick(1);
    chk(1'b1, "R6 clear edge");
  endtask

  task automatic t_clear_restart();
    fb_lo_i[1] = 1'b0;
    tick(D);
    chk(1'b0, "R6 setup fault");
    set_match(8'hA5);
    tick(C - 1);
    fb_lo_i[1] = 1'b0;
    tick(1);
    set_match(8'hA5);
    tick(C - 1);
    chk(1'b0, "R6 restart holds low");
    tick(1);
    chk(1'b1, "R6 restart clear edge");
  endtask

  task automatic t_detect_restart();
    fb_hi_i[2] = 1'b0;
    tick(D - 1);
    set_match(8'hA5);
    tick(1);
    fb_hi_i[2] = 1'b0;
    tick(D - 1);
    chk(1'b1, "R8 interrupted run");
    tick(1);
    chk(1'b0, "R8 full run after restart");
    recover();
  endtask

  task automatic t_bands();
    // bit1 commanded low, mid-band reading
    fb_lo_i[1] = 1'b0; fb_hi_i[1] = 1'b0;
    tick(D);
    chk(1'b0, "R2 low cmd mid band");
    recover();
    // bit0 commanded high, sensed at low rail
    fb_hi_i[0] = 1'b0; fb_lo_i[0] = 1'b1;
    tick(D);
    chk(1'b0, "R2 high cmd at low rail");
    recover();
    // bit7 commanded high, mid band
    fb_hi_i[7] = 1'b0; fb_lo_i[7] = 1'b0;
    tick(D);
    chk(1'b0, "R2 high cmd mid band");
    recover();
  endtask

  task automatic t_each_channel();
    for (int ch = 0; ch < N; ch++) begin
      if (exp_lvl_i[ch]) fb_hi_i[ch] = 1'b0;
      else               fb_lo_i[ch] = 1'b0;
      tick(D);
      chk(1'b0, $sformatf("R3 channel %0d", ch));
      recover();
    end
  endtask

  task automatic t_disabled();
    drv_en_i[3] = 1'b0;
    fb_hi_i[3]  = 1'b0; fb_lo_i[3] = 1'b0;
    tick(D + 10);
    chk(1'b1, "R4 disabled channel ignored");
    drv_en_i[3] = 1'b1;
    tick(D);
    chk(1'b0, "R4 enabled channel checked");
    recover();
  endtask

  task automatic t_transition();
    int l;
    l = 10;
    exp_lvl_i[1] = 1'b1;     // 0 -> 1, feedback lags
    tick(D - 1);
    chk(1'b1, "R7 before pulse");
    tick(1);
    chk(1'b0, "R7 pulse start");
    tick(l - D);
    set_match(8'hA7);
    tick(C - 1);
    chk(1'b0, "R7 pulse still low");
    tick(1);
    chk(1'b1, "R7 pulse end");
    exp_lvl_i[6] = 1'b1;     // short settle
    tick(D - 2);
    set_match(8'hE7);
    tick(D + 4);
    chk(1'b1, "R7 fast settle no pulse");
  endtask

  initial begin
    t_reset();
    t_detect();
    t_clear();
    t_clear_restart();
    t_detect_restart();
    t_bands();
    t_each_channel();
    t_disabled();
    t_transition();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, done=0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule